// File: doc/BRIEF.md
# Address-masked GPIO data port

This block is an 8-pin general-purpose I/O port that sits behind a simple APB-style register interface. It holds three registers: one for pin data, one for pin direction, and one that picks the control source for each pin. Software reaches the data register through a 256-word address window. The word index of each access acts as a per-bit mask. A single store can therefore set or clear chosen pins, and a single load can sample chosen pins, without a read-modify-write sequence.

Each pin drives a value and an output enable. Under software control these come from the data and direction registers. Under hardware control they come from two dedicated hardware inputs. Input pins pass through a two-stage synchronizer before reads can see them. Pad cells and interrupt logic sit outside the block.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to the data window (offsets 0x000 to 0x3FC, address bits [11:10] = 0) updates data bit i from `pwdata[i]` only when address bit i+2 is 1. Every other data bit keeps its value.
- R2: On a read of the data window, every bit i whose address bit i+2 is 0 returns 0. `prdata[31:8]` returns 0.
- R3: On a data read, bit i whose mask bit is 1 returns the stored data bit when the pin is an output. When the pin is an input, it returns `pin_in[i]` after two synchronizer stages: a change made between two clock edges is visible after the second edge, not after the first.
- R4: The direction register at offset 0x400 reads back what was written into `prdata[7:0]`. A direction bit of 1 makes the pin an output (`pin_oe` = 1 under software control), and 0 makes it an input.
- R5: The mode register at offset 0x420 reads back what was written. A mode bit of 1 routes `hw_out[i]` to `pin_out[i]` and `hw_oe[i]` to `pin_oe[i]`. A mode bit of 0 routes the data bit and the direction bit.
- R6: After reset, the data, direction and mode registers are all 0: every pin is an input under software control, with `pin_out` = 0 and `pin_oe` = 0.
- R7: A register changes only on a cycle where `psel`, `penable` and `pwrite` are all 1. A setup-phase cycle with `penable` = 0 changes nothing.
- R8: Reads of any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| hw_out | input | 8 | Hardware-control output values |
| hw_oe | input | 8 | Hardware-control output enables |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The hardest case to reach is a read whose result mixes three sources at once: pins set as outputs return stored data, pins set as inputs return synchronized levels, and unmasked bits return zero. Bringing this about needs a random direction pattern, a random stored value and a random mask to line up.

The stimulus sets up these mixes through random sequences of masked writes, direction writes, mode writes and input changes, followed by reads with random masks. A directed sequence covers the synchronizer. It changes `pin_in` between edges while a read is held, then samples after the first edge and again after the second edge.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int N_PINS   = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter logic [11:0] DIR_OFS  = 12'h400,
  parameter logic [11:0] MODE_OFS = 12'h420
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] hw_out,
  input  logic [N_PINS-1:0] hw_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe
);
  localparam int MSB = N_PINS + 1;

  logic [N_PINS-1:0] data_q, dir_q, mode_q, sync1_q, sync2_q;
  logic [N_PINS-1:0] mask;
  logic in_win, dir_hit, mode_hit, wr_en;

  assign mask     = paddr[MSB:2];
  assign in_win   = (paddr[ADDR_W-1:MSB+1] == '0);
  assign dir_hit  = (paddr == ADDR_W'(DIR_OFS));
  assign mode_hit = (paddr == ADDR_W'(MODE_OFS));
  assign wr_en    = psel && penable && pwrite;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      data_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (in_win)   data_q <= (data_q & ~mask) | (pwdata[N_PINS-1:0] & mask);
      if (dir_hit)  dir_q  <= pwdata[N_PINS-1:0];
      if (mode_hit) mode_q <= pwdata[N_PINS-1:0];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    prdata = '0;
    if (in_win)        prdata[N_PINS-1:0] = ((dir_q & data_q) | (~dir_q & sync2_q)) & mask;
    else if (dir_hit)  prdata[N_PINS-1:0] = dir_q;
    else if (mode_hit) prdata[N_PINS-1:0] = mode_q;
  end

  assign pin_out = (mode_q & hw_out) | (~mode_q & data_q);
  assign pin_oe  = (mode_q & hw_oe)  | (~mode_q & dir_q);

  a_r1_unmasked_kept: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_en && in_win) |=> (((data_q ^ $past(data_q)) & ~$past(mask)) == '0));

  a_r1_masked_loaded: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_en && in_win) |=> ((data_q & $past(mask)) == ($past(pwdata[N_PINS-1:0]) & $past(mask))));

  a_r2_read_masked: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && in_win) |-> ((prdata[N_PINS-1:0] & ~mask) == '0 && prdata[DATA_W-1:N_PINS] == '0));

  a_r7_no_write_idle: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_en |=> ($stable(data_q) && $stable(dir_q) && $stable(mode_q)));

  a_r8_unmapped_zero: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !in_win && !dir_hit && !mode_hit) |-> (prdata == '0));

  a_r8_unmapped_write: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_en && !in_win && !dir_hit && !mode_hit) |=> ($stable(data_q) && $stable(dir_q) && $stable(mode_q)));
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
  logic clk = 0, presetn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [7:0] pin_in = '0, hw_out = '0, hw_oe = '0, pin_out, pin_oe;
  logic [7:0] m_data = '0, m_dir = '0, m_mode = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_mask_port u_dut (.pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .hw_out(hw_out), .hw_oe(hw_oe), .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [31:0] exp_read(logic [11:0] a);
    if (a[11:10] == 2'b00) return {24'h0, ((m_dir & m_data) | (~m_dir & pin_in)) & a[9:2]};
    if (a == 12'h400) return {24'h0, m_dir};
    if (a == 12'h420) return {24'h0, m_mode};
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_pins(string req);
    chk({req, " pin_out"}, {24'h0, pin_out}, {24'h0, (m_mode & hw_out) | (~m_mode & m_data)});
    chk({req, " pin_oe"},  {24'h0, pin_oe},  {24'h0, (m_mode & hw_oe) | (~m_mode & m_dir)});
  endtask

  task automatic apb_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    if (a[11:10] == 2'b00) m_data = (m_data & ~a[9:2]) | (d[7:0] & a[9:2]);
    else if (a == 12'h400) m_dir = d[7:0];
    else if (a == 12'h420) m_mode = d[7:0];
  endtask

  task automatic apb_rd(logic [11:0] a, string req);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1;
    chk(req, prdata, exp_read(a));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk); pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    presetn = 1;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 pin_out", {24'h0, pin_out}, 32'h0);
    chk("R6 pin_oe", {24'h0, pin_oe}, 32'h0);
    apb_rd(12'h400, "R6 dir reset");
    apb_rd(12'h420, "R6 mode reset");
    apb_rd(12'h3FC, "R6 data reset");

    // R1 directed masked write
    apb_wr(12'h400, 32'hFF);
    apb_wr(12'h3FC, 32'hA5);
    apb_wr(12'h00C, 32'h00);
    apb_rd(12'h3FC, "R1 masked write clears bits 1:0 only");
    chk_pins("R1 R4");
    // R2 partial mask read
    apb_rd(12'h154, "R2 mask 0x55");
    // R7 setup-only write
    @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h3FC; pwdata = 32'h0F;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_rd(12'h3FC, "R7 setup phase ignored");
    // R8 unmapped
    apb_wr(12'h404, 32'hFF);
    apb_rd(12'h404, "R8 unmapped read");
    apb_rd(12'h420, "R8 unmapped write left mode");
    // R5 hardware control
    hw_out = 8'h3C; hw_oe = 8'hC3;
    apb_wr(12'h420, 32'h0F);
    apb_rd(12'h420, "R5 mode readback");
    chk_pins("R5 hw mux");

    // R3 synchronizer latency
    apb_wr(12'h400, 32'h00);
    set_pins(8'h00);
    @(negedge clk); psel = 1; pwrite = 0; paddr = 12'h3FC;
    @(negedge clk); pin_in = 8'h96;
    @(negedge clk); chk("R3 not visible after one edge", prdata, 32'h0);
    @(negedge clk); chk("R3 visible after two edges", prdata, 32'h96);
    psel = 0;

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 6);
      case (op)
        0: apb_wr({2'b00, 8'($urandom), 2'b00}, $urandom);
        1: apb_wr(12'h400, $urandom);
        2: apb_wr(12'h420, $urandom);
        3: set_pins(8'($urandom));
        4: begin hw_out = 8'($urandom); hw_oe = 8'($urandom); end
        5: apb_wr({2'b10, 8'($urandom), 2'b00}, $urandom);
        default: ;
      endcase
      apb_rd({2'b00, 8'($urandom), 2'b00}, "R3 R2 random data read");
      if (i % 8 == 0) apb_rd(12'h400, "R4 random dir read");
      if (i % 8 == 4) apb_rd(12'h420, "R5 random mode read");
      if (i % 16 == 2) apb_rd({2'b11, 8'($urandom), 2'b00}, "R8 random unmapped");
      #1; chk_pins("R5 random pins");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule